// File: doc/BRIEF.md
# Memory ECC error capture unit

This unit sits next to the read path of a DRAM controller and records ECC failures. On each read beat the controller presents the beat's address, its 64 data bits and its syndrome. It also marks the beat as carrying a correctable (single-bit) error, an uncorrectable (multi-bit) error, or neither. The unit keeps sticky status flags, and it snapshots the beat that first raised a flag. It counts correctable errors against a programmable threshold, so that isolated soft errors need not raise an interrupt. It drives one interrupt line that is gated by per-type enables.

Software reaches the unit through a flat 32-bit register port with word addresses. Writes take effect at the clock edge and reads are combinational. The same register space holds the error-injection masks that the controller's write path applies. These are XOR masks for the upper and lower data words and for the check byte, and all three are gated by one arm bit. The beat input is a plain valid strobe with no ready signal. The unit takes one beat on every cycle that `beat_valid` is high and never applies back-pressure, so the controller needs no stall logic.

Top module: `ecc_err_capture`

Register word map, with all fields reset to zero:

| Word | Name | Contents |
|---|---|---|
| 0 | status | bit 0 correctable flag, bit 1 uncorrectable flag; writing 1 clears a flag |
| 1 | irq enable | bit 0 correctable, bit 1 uncorrectable |
| 2 | detect off | bit 0 correctable, bit 1 uncorrectable |
| 3 | threshold | bits 23:16 threshold (read/write), bits 7:0 running count (read-only) |
| 4 | config | bit 0 narrow bus: 1 selects a 32-bit bus, 0 a 64-bit bus |
| 5 | captured data, upper word | data bits 63:32 |
| 6 | captured data, lower word | data bits 31:0 |
| 7 | captured syndrome | low 8 or low 16 bits, per bus width |
| 8 | captured address, low | address bits 31:0 |
| 9 | captured address, high | address bits above 31 |
| 10 | inject mask, upper data | 32-bit mask |
| 11 | inject mask, lower data | 32-bit mask |
| 12 | inject control | bits 7:0 check-byte mask, bit 8 arm |

## Requirements
- R1: Status word 0 has a correctable flag at bit 0 and an uncorrectable flag at bit 1. Once set, a flag stays set until software writes a 1 to that bit. Writing 0xFFFFFFFF clears both flags. If a flag is set and cleared in the same cycle, the set wins.
- R2: `irq` is high exactly when a status flag is set and its enable in word 1 is set (bit 0 correctable, bit 1 uncorrectable).
- R3: Word 2 bit 0 turns off correctable detection: such beats do not count, set no flag and cause no capture. Word 2 bit 1 does the same for uncorrectable beats. Writing 0 to word 2 turns detection on for both types.
- R4: Words 5 to 9 load from the beat that sets a flag, but only while no flag is currently set. They then keep that value until status is cleared.
- R5: Word 3 bits 23:16 hold the threshold and bits 7:0 show the running count of detected correctable beats. When the count reaches the threshold, the correctable flag sets and the count returns to 0. Writing 0x00010000 makes every correctable beat set the flag.
- R6: A threshold of 0 stops counting: the count holds and correctable beats never set the flag.
- R7: Word 4 bit 0 = 0 selects a 64-bit bus, and word 7 keeps only syndrome bits 7:0. Word 4 bit 0 = 1 selects a 32-bit bus, and word 7 keeps syndrome bits 15:0.
- R8: Words 10 and 11 read back their full 32-bit value. Word 12 reads back bits 8:0 as written, with zeros above.
- R9: When word 12 bit 8 is set, `inj_data_hi`, `inj_data_lo` and `inj_chk` equal word 10, word 11 and word 12 bits 7:0. When that bit is clear, all three outputs are 0.
- R10: After reset every register reads 0 and `irq` is low. Word addresses 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wen | input | 1 | Write strobe, takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| beat_valid | input | 1 | A read beat is presented; always accepted |
| beat_sbe | input | 1 | Beat carries a correctable error |
| beat_mbe | input | 1 | Beat carries an uncorrectable error |
| beat_addr | input | ADDR_W | Beat address |
| beat_data | input | 64 | Beat data as read |
| beat_syn | input | 16 | Beat syndrome |
| irq | output | 1 | Interrupt request |
| inj_data_hi | output | 32 | XOR mask for data bits 63:32 on writes |
| inj_data_lo | output | 32 | XOR mask for data bits 31:0 on writes |
| inj_chk | output | 8 | XOR mask for the check byte on writes |

## Verification
The assertions check four properties on every cycle. A flag stays set unless a write clears it. With a type turned off, its flag cannot rise. The capture registers hold while any flag is up. The counter returns to zero on a hit and stays still at a zero threshold. They also check that the inject outputs are silent while unarmed. Only the bench scenarios can show which beat lands in the capture words and the exact count at which the flag rises. The same holds for the syndrome width in each bus mode and for set-over-clear priority in a single cycle. The interrupt gating and the read-back of every register likewise depend on those scenarios.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 4;
  localparam int DATA_W = 64;
  localparam int SYN_W  = 16;
  localparam int THR_W  = 8;
  localparam int INJ_CW = 9;

  localparam logic [REG_AW-1:0] RI_STATUS   = 4'd0;
  localparam logic [REG_AW-1:0] RI_IRQ_EN   = 4'd1;
  localparam logic [REG_AW-1:0] RI_DET_OFF  = 4'd2;
  localparam logic [REG_AW-1:0] RI_THRESH   = 4'd3;
  localparam logic [REG_AW-1:0] RI_CONFIG   = 4'd4;
  localparam logic [REG_AW-1:0] RI_CAP_DHI  = 4'd5;
  localparam logic [REG_AW-1:0] RI_CAP_DLO  = 4'd6;
  localparam logic [REG_AW-1:0] RI_CAP_SYN  = 4'd7;
  localparam logic [REG_AW-1:0] RI_CAP_ALO  = 4'd8;
  localparam logic [REG_AW-1:0] RI_CAP_AHI  = 4'd9;
  localparam logic [REG_AW-1:0] RI_INJ_HI   = 4'd10;
  localparam logic [REG_AW-1:0] RI_INJ_LO   = 4'd11;
  localparam logic [REG_AW-1:0] RI_INJ_CTRL = 4'd12;

  typedef struct packed {
    logic mbe;
    logic sbe;
  } err_pair_t;
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thr,
  input  logic             sbe_det,
  output logic [THR_W-1:0] cnt,
  output logic             hit
);
  logic [THR_W:0] cnt_inc;
  logic           active;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign active  = sbe_det && (thr != '0);
  assign hit     = active && (cnt_inc >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (active) cnt <= hit ? '0 : cnt_inc[THR_W-1:0];
  end

  // R5: a threshold hit leaves the count at zero
  a_r5_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
  // R6: a zero threshold freezes the count
  a_r6_zero_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |=> $stable(cnt));
endmodule

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              narrow,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [SYN_W-1:0]  syn,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [SYN_W-1:0]  cap_syn
);
  localparam int WIDE_SYN = 8;

  logic [SYN_W-1:0] syn_kept;

  always_comb begin
    syn_kept = syn;
    if (!narrow) syn_kept = {{(SYN_W-WIDE_SYN){1'b0}}, syn[WIDE_SYN-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_syn  <= '0;
    end else if (load) begin
      cap_addr <= addr;
      cap_data <= data;
      cap_syn  <= syn_kept;
    end
  end
endmodule

// File: rtl/ecc_inject_ctl.sv
module ecc_inject_ctl #(
  parameter int REG_W  = 32,
  parameter int INJ_CW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_hi,
  input  logic              wen_lo,
  input  logic              wen_ctrl,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  mask_hi_q,
  output logic [REG_W-1:0]  mask_lo_q,
  output logic [INJ_CW-1:0] ctrl_q,
  output logic [REG_W-1:0]  inj_hi,
  output logic [REG_W-1:0]  inj_lo,
  output logic [INJ_CW-2:0] inj_chk
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (wen_hi)   mask_hi_q <= wdata;
      if (wen_lo)   mask_lo_q <= wdata;
      if (wen_ctrl) ctrl_q    <= wdata[INJ_CW-1:0];
    end
  end

  assign armed   = ctrl_q[INJ_CW-1];
  assign inj_hi  = armed ? mask_hi_q : '0;
  assign inj_lo  = armed ? mask_lo_q : '0;
  assign inj_chk = armed ? ctrl_q[INJ_CW-2:0] : '0;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              beat_valid,
  input  logic              beat_sbe,
  input  logic              beat_mbe,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [SYN_W-1:0]  beat_syn,
  output logic              irq,
  output logic [REG_W-1:0]  inj_data_hi,
  output logic [REG_W-1:0]  inj_data_lo,
  output logic [7:0]        inj_chk
);
  localparam int ADDR_PAD = 2*REG_W - ADDR_W;
  localparam int THR_LSB  = 16;

  err_pair_t        st_q, irq_en_q, det_off_q, set_now, clr_now;
  logic             narrow_q;
  logic [THR_W-1:0] thr_q, sbe_cnt;
  logic             sbe_det, sbe_hit, cap_load;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [SYN_W-1:0]  cap_syn;
  logic [2*REG_W-1:0] cap_addr_ext;
  logic [REG_W-1:0]  inj_hi_q, inj_lo_q;
  logic [INJ_CW-1:0] inj_ctrl_q;
  logic              wr_status;

  assign wr_status = reg_wen && (reg_addr == RI_STATUS);
  assign sbe_det   = beat_valid && beat_sbe && !det_off_q.sbe;
  assign set_now.sbe = sbe_hit;
  assign set_now.mbe = beat_valid && beat_mbe && !det_off_q.mbe;
  assign clr_now   = wr_status ? err_pair_t'(reg_wdata[1:0]) : '0;
  assign cap_load  = (set_now != '0) && (st_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      irq_en_q  <= '0;
      det_off_q <= '0;
      thr_q     <= '0;
      narrow_q  <= 1'b0;
    end else begin
      st_q <= (st_q & ~clr_now) | set_now;
      if (reg_wen) begin
        case (reg_addr)
          RI_IRQ_EN:  irq_en_q  <= err_pair_t'(reg_wdata[1:0]);
          RI_DET_OFF: det_off_q <= err_pair_t'(reg_wdata[1:0]);
          RI_THRESH:  thr_q     <= reg_wdata[THR_LSB +: THR_W];
          RI_CONFIG:  narrow_q  <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign irq = |(st_q & irq_en_q);

  ecc_sbe_counter #(.THR_W(THR_W)) u_count (
    .clk(clk), .rst_n(rst_n), .thr(thr_q), .sbe_det(sbe_det),
    .cnt(sbe_cnt), .hit(sbe_hit)
  );

  ecc_capture_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load), .narrow(narrow_q),
    .addr(beat_addr), .data(beat_data), .syn(beat_syn),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_syn(cap_syn)
  );

  ecc_inject_ctl #(.REG_W(REG_W), .INJ_CW(INJ_CW)) u_inj (
    .clk(clk), .rst_n(rst_n),
    .wen_hi(reg_wen && reg_addr == RI_INJ_HI),
    .wen_lo(reg_wen && reg_addr == RI_INJ_LO),
    .wen_ctrl(reg_wen && reg_addr == RI_INJ_CTRL),
    .wdata(reg_wdata),
    .mask_hi_q(inj_hi_q), .mask_lo_q(inj_lo_q), .ctrl_q(inj_ctrl_q),
    .inj_hi(inj_data_hi), .inj_lo(inj_data_lo), .inj_chk(inj_chk)
  );

  assign cap_addr_ext = {{ADDR_PAD{1'b0}}, cap_addr};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_STATUS:   reg_rdata[1:0] = st_q;
      RI_IRQ_EN:   reg_rdata[1:0] = irq_en_q;
      RI_DET_OFF:  reg_rdata[1:0] = det_off_q;
      RI_THRESH:   begin
                     reg_rdata[THR_LSB +: THR_W] = thr_q;
                     reg_rdata[THR_W-1:0]        = sbe_cnt;
                   end
      RI_CONFIG:   reg_rdata[0] = narrow_q;
      RI_CAP_DHI:  reg_rdata = cap_data[DATA_W-1:REG_W];
      RI_CAP_DLO:  reg_rdata = cap_data[REG_W-1:0];
      RI_CAP_SYN:  reg_rdata[SYN_W-1:0] = cap_syn;
      RI_CAP_ALO:  reg_rdata = cap_addr_ext[REG_W-1:0];
      RI_CAP_AHI:  reg_rdata = cap_addr_ext[2*REG_W-1:REG_W];
      RI_INJ_HI:   reg_rdata = inj_hi_q;
      RI_INJ_LO:   reg_rdata = inj_lo_q;
      RI_INJ_CTRL: reg_rdata[INJ_CW-1:0] = inj_ctrl_q;
      default:     reg_rdata = '0;
    endcase
  end

  // R1: a correctable flag survives unless a write clears its bit
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.sbe && !(wr_status && reg_wdata[0])) |=> st_q.sbe);
  // R3: uncorrectable detection off keeps a clear flag clear
  a_r3_mbe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (det_off_q.mbe && !st_q.mbe) |=> !st_q.mbe);
  // R4: the capture registers hold while any flag is up
  a_r4_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != '0) |=> ($stable(cap_data) && $stable(cap_addr) && $stable(cap_syn)));
  // R9: the inject outputs stay silent while unarmed
  a_r9_inject_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_ctrl_q[INJ_CW-1] |-> (inj_data_hi == '0 && inj_data_lo == '0 && inj_chk == '0));
endmodule

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        beat_valid = 1'b0, beat_sbe = 1'b0, beat_mbe = 1'b0;
  logic [39:0] beat_addr = '0;
  logic [63:0] beat_data = '0;
  logic [15:0] beat_syn = '0;
  logic        irq;
  logic [31:0] inj_data_hi, inj_data_lo;
  logic [7:0]  inj_chk;
  int checks = 0, errors = 0;
  logic [31:0] v;

  ecc_err_capture u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
    .beat_sbe(beat_sbe), .beat_mbe(beat_mbe), .beat_addr(beat_addr),
    .beat_data(beat_data), .beat_syn(beat_syn), .irq(irq),
    .inj_data_hi(inj_data_hi), .inj_data_lo(inj_data_lo), .inj_chk(inj_chk)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic beat(input logic s, input logic m, input logic [39:0] a,
                      input logic [63:0] d, input logic [15:0] y);
    @(negedge clk);
    beat_valid = 1'b1; beat_sbe = s; beat_mbe = m;
    beat_addr = a; beat_data = d; beat_syn = y;
    @(negedge clk);
    beat_valid = 1'b0; beat_sbe = 1'b0; beat_mbe = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      check("R10 reset/unmapped read", {32'h0, v}, 64'h0);
    end
    check("R10 irq at reset", {63'h0, irq}, 64'h0);
    check("R9 inject outputs at reset", {inj_data_hi, inj_data_lo}, 64'h0);
  endtask

  task automatic t_mbe_capture;
    wr(4'd1, 32'h2);
    beat(1'b0, 1'b1, 40'h12_3456_789A, 64'hDEADBEEF_01234567, 16'hABCD);
    rd(4'd0, v); check("R1 mbe flag set", {32'h0, v}, 64'h2);
    check("R2 irq mbe enabled", {63'h0, irq}, 64'h1);
    rd(4'd5, v); check("R4 cap data hi", {32'h0, v}, 64'hDEADBEEF);
    rd(4'd6, v); check("R4 cap data lo", {32'h0, v}, 64'h01234567);
    rd(4'd7, v); check("R7 cap syndrome 64-bit bus", {32'h0, v}, 64'hCD);
    rd(4'd8, v); check("R4 cap addr lo", {32'h0, v}, 64'h3456789A);
    rd(4'd9, v); check("R4 cap addr hi", {32'h0, v}, 64'h12);
    beat(1'b0, 1'b1, 40'h0, 64'h11111111_22222222, 16'h0);
    rd(4'd5, v); check("R4 first error kept", {32'h0, v}, 64'hDEADBEEF);
    wr(4'd0, 32'h2);
    rd(4'd0, v); check("R1 w1c clears mbe", {32'h0, v}, 64'h0);
    check("R2 irq drops", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_threshold;
    wr(4'd3, 32'h0003_0000);
    beat(1'b1, 1'b0, 40'h1, 64'h1, 16'h1);
    beat(1'b1, 1'b0, 40'h2, 64'h2, 16'h2);
    rd(4'd3, v); check("R5 count at two", {32'h0, v}, 64'h0003_0002);
    rd(4'd0, v); check("R5 no flag below threshold", {32'h0, v}, 64'h0);
    beat(1'b1, 1'b0, 40'h3, 64'h33, 16'h3);
    rd(4'd0, v); check("R5 flag at threshold", {32'h0, v}, 64'h1);
    rd(4'd3, v); check("R5 count back to zero", {32'h0, v}, 64'h0003_0000);
    rd(4'd6, v); check("R4 capture of hitting beat", {32'h0, v}, 64'h33);
    check("R2 irq sbe not enabled", {63'h0, irq}, 64'h0);
    wr(4'd1, 32'h3);
    #1 check("R2 irq sbe enabled", {63'h0, irq}, 64'h1);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R1 all-ones clears", {32'h0, v}, 64'h0);
    wr(4'd3, 32'h0001_0000);
    beat(1'b1, 1'b0, 40'h4, 64'h4, 16'h4);
    rd(4'd0, v); check("R5 threshold one flags each", {32'h0, v}, 64'h1);
    wr(4'd0, 32'h1);
  endtask

  task automatic t_zero_thr;
    wr(4'd3, 32'h0);
    for (int i = 0; i < 3; i++) beat(1'b1, 1'b0, 40'h5, 64'h5, 16'h5);
    rd(4'd0, v); check("R6 no flag at zero threshold", {32'h0, v}, 64'h0);
    rd(4'd3, v); check("R6 count held", {32'h0, v}, 64'h0);
  endtask

  task automatic t_disable;
    wr(4'd3, 32'h0001_0000);
    wr(4'd2, 32'h3);
    beat(1'b1, 1'b0, 40'h6, 64'h66, 16'h6);
    beat(1'b0, 1'b1, 40'h7, 64'h77, 16'h7);
    rd(4'd0, v); check("R3 disabled types set nothing", {32'h0, v}, 64'h0);
    rd(4'd6, v); check("R3 no capture when disabled", {32'h0, v}, 64'h4);
    wr(4'd2, 32'h0);
    beat(1'b0, 1'b1, 40'h8, 64'h88, 16'h8);
    rd(4'd0, v); check("R3 re-enabled mbe", {32'h0, v}, 64'h2);
    wr(4'd0, 32'h3);
  endtask

  task automatic t_bus32;
    wr(4'd4, 32'h1);
    @(negedge clk);
    beat_valid = 1'b1; beat_mbe = 1'b1; beat_syn = 16'hABCD; beat_data = 64'h9;
    reg_addr = 4'd0; reg_wdata = 32'h3; reg_wen = 1'b1;
    @(negedge clk);
    beat_valid = 1'b0; beat_mbe = 1'b0; reg_wen = 1'b0;
    rd(4'd0, v); check("R1 set wins over clear", {32'h0, v}, 64'h2);
    rd(4'd7, v); check("R7 cap syndrome 32-bit bus", {32'h0, v}, 64'hABCD);
    wr(4'd0, 32'h3);
  endtask

  task automatic t_inject;
    wr(4'd10, 32'hA5A5_A5A5);
    wr(4'd11, 32'h5A5A_0F0F);
    wr(4'd12, 32'h0000_00C3);
    #1 check("R9 unarmed outputs zero", {inj_data_hi, inj_data_lo}, 64'h0);
    check("R9 unarmed chk zero", {56'h0, inj_chk}, 64'h0);
    rd(4'd10, v); check("R8 inject hi readback", {32'h0, v}, 64'hA5A5A5A5);
    rd(4'd11, v); check("R8 inject lo readback", {32'h0, v}, 64'h5A5A0F0F);
    wr(4'd12, 32'h0000_01C3);
    #1 check("R9 armed data masks", {inj_data_hi, inj_data_lo}, 64'hA5A5A5A5_5A5A0F0F);
    check("R9 armed chk mask", {56'h0, inj_chk}, 64'hC3);
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd12, v); check("R8 ctrl keeps bits 8:0", {32'h0, v}, 64'h1FF);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mbe_capture();
    t_threshold();
    t_zero_thr();
    t_disable();
    t_bus32();
    t_inject();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule